// File: doc/BRIEF.md
# Configurable Logic Output Cell

This block models a single programmable output cell. A sum-of-products term arrives from an upstream allocator, may be inverted by a polarity bit, and is stored in an element that acts as a D register, a toggle register or a transparent latch. A pad input can replace the logic term as the data source, either directly or after a short delay stage, so the cell can serve as a fast input register. The stored value drives a local output path and a global routing path.

All behaviour runs on one system clock `clk`. The eight candidate cell clocks are ordinary level inputs. The cell detects a rising level of the chosen source at a system clock edge and treats it as a clock event. A per-cell enable term qualifies every update. Two init terms force the stored value at once. The configuration inputs are captured while `rstN` is low and must be held steady afterwards. During reset the stored value takes the power-up init value.

Top module: `pldCell`

## Requirements
- R1: While `rstN` is low, the stored value loads `cfgInitPreset`. After reset, `localOut` equals that value until an update occurs.
- R2: With `cfgMode` = 0 (D), the cell loads the data value at a system clock edge on which the selected source is 1 and was 0 at the previous edge. Without such an edge the output holds. Mode 3 behaves like mode 0.
- R3: On the logic path the data value is `sumIn` XOR `cfgXorInv`.
- R4: With `cfgMode` = 1 (T), a source rising edge inverts the stored value when the data value is 1 and leaves it unchanged when the data value is 0.
- R5: With `cfgMode` = 2 (latch), the output follows the data value combinationally while the selected source is 1. When the source returns to 0, the output keeps the last value seen at a system clock edge.
- R6: When `ptClkEn` is 0, no source edge and no open latch changes the output.
- R7: `cfgClkSel` values 0 to 3 pick `blkClk[0]` to `blkClk[3]`. Value 4 picks `sharedPtClk`, value 5 picks `ptClk`, and value 6 picks the inverse of `ptClk`, so a falling `ptClk` is an event. Value 7 is constant 0 and never updates the cell.
- R8: While `sharedInit` or `ptInit` is 1, the output equals `cfgInitPreset` in the same cycle, regardless of the clock and the enable. That value remains stored after the init is released.
- R9: With `cfgUseDirect` = 1, the data value comes from `padIn`. In that case `sumIn` and `cfgXorInv` have no effect.
- R10: With `cfgDelayOn` = 1, the direct data value is `padIn` as sampled two system clock edges earlier. With `cfgDelayOn` = 0 it is the current `padIn`.
- R11: `localOut` and `globalOut` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset; configuration capture and power-up init |
| cfgXorInv | input | 1 | Logic path polarity: 1 inverts `sumIn` |
| cfgMode | input | 2 | Storage mode: 0 D, 1 T, 2 latch, 3 D |
| cfgClkSel | input | 3 | Clock source select (see R7) |
| cfgUseDirect | input | 1 | 1 takes data from the pad path |
| cfgDelayOn | input | 1 | 1 inserts the pad delay stage |
| cfgInitPreset | input | 1 | Init and power-up value |
| blkClk | input | 4 | Shared block clock levels |
| sharedPtClk | input | 1 | Shared product-term clock level |
| ptClk | input | 1 | Per-cell product-term clock level |
| ptClkEn | input | 1 | Per-cell clock enable term |
| sharedInit | input | 1 | Shared init term, active high |
| ptInit | input | 1 | Per-cell init term, active high |
| sumIn | input | 1 | Sum-of-products term from the allocator |
| padIn | input | 1 | Direct pad input |
| localOut | output | 1 | Stored value to local output routing |
| globalOut | output | 1 | Stored value to global routing |

## Verification
The bench builds the cell with its default two-stage pad delay. With that setting, a pad change launched in the same cycle as a capture edge reaches the register only two edges later, so the bench can tell the delayed path from the direct path. Every value of the clock select is used in turn, including the inverted per-cell term and the disabled setting. Each storage mode is run with enable on and enable off, and both init sources are tested against both preset polarities.

// File: rtl/pldCellPkg.sv
package pldCellPkg;

  localparam int NUM_BLK_CLK = 4;
  localparam int NUM_CLK_SRC = 8;
  localparam int CLK_SEL_W   = $clog2(NUM_CLK_SRC);

  typedef enum logic [1:0] {
    MODE_D     = 2'd0,
    MODE_T     = 2'd1,
    MODE_LATCH = 2'd2,
    MODE_RSVD  = 2'd3
  } storeMode_e;

  typedef struct packed {
    logic                 xorInv;
    storeMode_e           mode;
    logic [CLK_SEL_W-1:0] clkSel;
    logic                 useDirect;
    logic                 delayOn;
    logic                 initPreset;
  } cellCfg_t;

  typedef struct packed {
    logic capture;
    logic latchOpen;
    logic initForce;
  } cellStrb_t;

endpackage

// File: rtl/pldCellCtrl.sv
module pldCellCtrl
  import pldCellPkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  cellCfg_t               cfgIn,
  input  logic [NUM_BLK_CLK-1:0] blkClk,
  input  logic                   sharedPtClk,
  input  logic                   ptClk,
  input  logic                   ptClkEn,
  input  logic                   sharedInit,
  input  logic                   ptInit,
  output cellCfg_t               cfg,
  output cellStrb_t              strb
);

  localparam int SEL_SHARED = NUM_BLK_CLK;
  localparam int SEL_PT     = NUM_BLK_CLK + 1;
  localparam int SEL_PT_INV = NUM_BLK_CLK + 2;
  localparam int SEL_OFF    = NUM_CLK_SRC - 1;

  logic [NUM_CLK_SRC-1:0] srcVec;
  logic                   srcLevel;
  logic                   srcPrev;
  logic                   srcRise;
  logic                   isLatch;

  // configuration is captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) cfg <= cfgIn;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BLK_CLK; gi++) begin : gBlkSrc
      assign srcVec[gi] = blkClk[gi];
    end
  endgenerate

  assign srcVec[SEL_SHARED] = sharedPtClk;
  assign srcVec[SEL_PT]     = ptClk;
  assign srcVec[SEL_PT_INV] = ~ptClk;
  assign srcVec[SEL_OFF]    = 1'b0;

  assign srcLevel = srcVec[cfg.clkSel];

  // previous level starts high so a source already high at reset gives no event
  always_ff @(posedge clk) begin
    if (!rstN) srcPrev <= 1'b1;
    else       srcPrev <= srcLevel;
  end

  assign srcRise = srcLevel & ~srcPrev;
  assign isLatch = (cfg.mode == MODE_LATCH);

  always_comb begin
    strb           = '0;
    strb.capture   = ~isLatch & srcRise & ptClkEn;
    strb.latchOpen = isLatch & srcLevel & ptClkEn;
    strb.initForce = sharedInit | ptInit;
  end

  // R7: the disabled source never produces an update strobe
  assert_disabled_src_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.clkSel == CLK_SEL_W'(SEL_OFF)) |-> !(strb.capture || strb.latchOpen));

  // R2: one event per rising level, never on two consecutive edges
  assert_single_event_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> !strb.capture);

  // R6: no strobe while the enable term is low
  assert_enable_gates_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ptClkEn |-> !(strb.capture || strb.latchOpen));

endmodule

// File: rtl/pldCellPath.sv
module pldCellPath
  import pldCellPkg::*;
#(
  parameter int DELAY_STAGES = 2
)(
  input  logic      clk,
  input  logic      rstN,
  input  logic      resetVal,
  input  cellCfg_t  cfg,
  input  cellStrb_t strb,
  input  logic      sumIn,
  input  logic      padIn,
  output logic      qOut
);

  localparam int LINE_LEN = (DELAY_STAGES > 0) ? DELAY_STAGES : 1;

  logic [LINE_LEN-1:0] padLine;
  logic                padDelayed;
  logic                padData;
  logic                logicData;
  logic                dataIn;
  logic                qReg;
  logic                qNext;

  generate
    if (DELAY_STAGES > 0) begin : gDelay
      always_ff @(posedge clk) begin
        if (!rstN) padLine <= '0;
        else       padLine <= {padLine[LINE_LEN-2+((LINE_LEN==1)?1:0):0], padIn};
      end
      assign padDelayed = padLine[LINE_LEN-1];
    end else begin : gNoDelay
      assign padLine    = '0;
      assign padDelayed = padIn;
    end
  endgenerate

  assign padData   = cfg.delayOn ? padDelayed : padIn;
  assign logicData = sumIn ^ cfg.xorInv;
  assign dataIn    = cfg.useDirect ? padData : logicData;

  always_comb begin
    qNext = qReg;
    if (strb.initForce) begin
      qNext = cfg.initPreset;
    end else begin
      unique case (cfg.mode)
        MODE_T:     if (strb.capture)   qNext = qReg ^ dataIn;
        MODE_LATCH: if (strb.latchOpen) qNext = dataIn;
        default:    if (strb.capture)   qNext = dataIn;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) qReg <= resetVal;
    else       qReg <= qNext;
  end

  always_comb begin
    if (strb.initForce)     qOut = cfg.initPreset;
    else if (strb.latchOpen) qOut = dataIn;
    else                     qOut = qReg;
  end

  // R8: an active init leaves the preset value stored
  assert_init_loads_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.initForce |=> (qReg == cfg.initPreset));

  // R2: D-type capture stores the data seen at the event
  assert_d_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.initForce && strb.capture && cfg.mode != MODE_T && cfg.mode != MODE_LATCH)
      |=> (qReg == $past(dataIn)));

  // R4: toggle mode flips on a one
  assert_t_flip_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.initForce && strb.capture && cfg.mode == MODE_T && dataIn)
      |=> (qReg != $past(qReg)));

  // R5: closed latch and idle register keep their value
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.initForce && !strb.capture && !strb.latchOpen) |=> $stable(qReg));

endmodule

// File: rtl/pldCell.sv
module pldCell
  import pldCellPkg::*;
#(
  parameter int DELAY_STAGES = 2
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgXorInv,
  input  logic [1:0]             cfgMode,
  input  logic [CLK_SEL_W-1:0]   cfgClkSel,
  input  logic                   cfgUseDirect,
  input  logic                   cfgDelayOn,
  input  logic                   cfgInitPreset,
  input  logic [NUM_BLK_CLK-1:0] blkClk,
  input  logic                   sharedPtClk,
  input  logic                   ptClk,
  input  logic                   ptClkEn,
  input  logic                   sharedInit,
  input  logic                   ptInit,
  input  logic                   sumIn,
  input  logic                   padIn,
  output logic                   localOut,
  output logic                   globalOut
);

  cellCfg_t  cfgIn;
  cellCfg_t  cfg;
  cellStrb_t strb;
  logic      qOut;

  always_comb begin
    cfgIn            = '0;
    cfgIn.xorInv     = cfgXorInv;
    cfgIn.mode       = storeMode_e'(cfgMode);
    cfgIn.clkSel     = cfgClkSel;
    cfgIn.useDirect  = cfgUseDirect;
    cfgIn.delayOn    = cfgDelayOn;
    cfgIn.initPreset = cfgInitPreset;
  end

  pldCellCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgIn       (cfgIn),
    .blkClk      (blkClk),
    .sharedPtClk (sharedPtClk),
    .ptClk       (ptClk),
    .ptClkEn     (ptClkEn),
    .sharedInit  (sharedInit),
    .ptInit      (ptInit),
    .cfg         (cfg),
    .strb        (strb)
  );

  pldCellPath #(.DELAY_STAGES(DELAY_STAGES)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .resetVal (cfgInitPreset),
    .cfg      (cfg),
    .strb     (strb),
    .sumIn    (sumIn),
    .padIn    (padIn),
    .qOut     (qOut)
  );

  assign localOut  = qOut;
  assign globalOut = qOut;

endmodule

// File: tb/sim_pldCell.sv
module sim_pldCell;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgXorInv = 1'b0;
  logic [1:0] cfgMode = 2'd0;
  logic [2:0] cfgClkSel = 3'd0;
  logic       cfgUseDirect = 1'b0;
  logic       cfgDelayOn = 1'b0;
  logic       cfgInitPreset = 1'b0;
  logic [3:0] blkClk = 4'd0;
  logic       sharedPtClk = 1'b0;
  logic       ptClk = 1'b0;
  logic       ptClkEn = 1'b1;
  logic       sharedInit = 1'b0;
  logic       ptInit = 1'b0;
  logic       sumIn = 1'b0;
  logic       padIn = 1'b0;
  logic       localOut;
  logic       globalOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pldCell u0 (
    .clk(clk), .rstN(rstN), .cfgXorInv(cfgXorInv), .cfgMode(cfgMode),
    .cfgClkSel(cfgClkSel), .cfgUseDirect(cfgUseDirect), .cfgDelayOn(cfgDelayOn),
    .cfgInitPreset(cfgInitPreset), .blkClk(blkClk), .sharedPtClk(sharedPtClk),
    .ptClk(ptClk), .ptClkEn(ptClkEn), .sharedInit(sharedInit), .ptInit(ptInit),
    .sumIn(sumIn), .padIn(padIn), .localOut(localOut), .globalOut(globalOut)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] mode, input logic [2:0] sel,
                         input logic xorInv, input logic direct,
                         input logic dly, input logic preset);
    @(negedge clk);
    rstN = 1'b0;
    cfgMode = mode; cfgClkSel = sel; cfgXorInv = xorInv;
    cfgUseDirect = direct; cfgDelayOn = dly; cfgInitPreset = preset;
    blkClk = '0; sharedPtClk = 0; ptClk = 0; ptClkEn = 1;
    sharedInit = 0; ptInit = 0; sumIn = 0; padIn = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // raise one source for one cycle: 0..3 block clocks, 4 shared, 5 per-cell
  task automatic pulseSrc(input int idx);
    if (idx < 4) blkClk[idx] = 1'b1;
    else if (idx == 4) sharedPtClk = 1'b1;
    else ptClk = 1'b1;
    @(negedge clk);
    blkClk = '0; sharedPtClk = 1'b0; ptClk = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    doReset(2'd0, 3'd0, 0, 0, 0, 1'b1);
    chk("R1 preset one after reset", localOut, 1'b1);
    chk("R11 outputs agree", globalOut, localOut);
    doReset(2'd0, 3'd0, 0, 0, 0, 1'b0);
    chk("R1 preset zero after reset", localOut, 1'b0);
  endtask

  task automatic testDMode();
    doReset(2'd0, 3'd0, 0, 0, 0, 1'b0);
    sumIn = 1; pulseSrc(0);
    chk("R2 D capture one", localOut, 1'b1);
    sumIn = 0; repeat (2) @(negedge clk);
    chk("R2 D hold without event", localOut, 1'b1);
    blkClk[0] = 1; repeat (3) @(negedge clk);
    sumIn = 1; @(negedge clk); sumIn = 0; @(negedge clk);
    chk("R2 D high level is not an event", localOut, 1'b0);
    blkClk[0] = 0; @(negedge clk);
    doReset(2'd3, 3'd0, 0, 0, 0, 1'b0);
    sumIn = 1; pulseSrc(0);
    chk("R2 mode 3 acts as D", localOut, 1'b1);
  endtask

  task automatic testXor();
    doReset(2'd0, 3'd0, 1, 0, 0, 1'b0);
    sumIn = 0; pulseSrc(0);
    chk("R3 inverted zero gives one", localOut, 1'b1);
    sumIn = 1; pulseSrc(0);
    chk("R3 inverted one gives zero", localOut, 1'b0);
  endtask

  task automatic testToggle();
    doReset(2'd1, 3'd2, 0, 0, 0, 1'b0);
    sumIn = 1; pulseSrc(2);
    chk("R4 toggle to one", localOut, 1'b1);
    pulseSrc(2);
    chk("R4 toggle back to zero", localOut, 1'b0);
    sumIn = 0; pulseSrc(2);
    chk("R4 zero data holds", localOut, 1'b0);
  endtask

  task automatic testLatch();
    doReset(2'd2, 3'd1, 0, 0, 0, 1'b0);
    blkClk[1] = 1; sumIn = 1; #1;
    chk("R5 latch transparent high", localOut, 1'b1);
    @(negedge clk); sumIn = 0; #1;
    chk("R5 latch follows low", localOut, 1'b0);
    @(negedge clk); sumIn = 1; #1;
    chk("R5 latch follows high again", localOut, 1'b1);
    @(negedge clk); blkClk[1] = 0; #1;
    chk("R5 latch closed keeps value", localOut, 1'b1);
    @(negedge clk); sumIn = 0; @(negedge clk);
    chk("R5 latch closed ignores data", localOut, 1'b1);
    ptClkEn = 0; blkClk[1] = 1; #1;
    chk("R6 latch disabled stays shut", localOut, 1'b1);
    @(negedge clk); blkClk[1] = 0; ptClkEn = 1; @(negedge clk);
    chk("R6 latch disabled stored nothing", localOut, 1'b1);
  endtask

  task automatic testEnable();
    doReset(2'd0, 3'd0, 0, 0, 0, 1'b0);
    ptClkEn = 0; sumIn = 1; pulseSrc(0);
    chk("R6 D disabled ignores edge", localOut, 1'b0);
    ptClkEn = 1; pulseSrc(0);
    chk("R6 D enabled takes edge", localOut, 1'b1);
  endtask

  task automatic testClkSel();
    for (int sel = 0; sel < 6; sel++) begin
      doReset(2'd0, 3'(sel), 0, 0, 0, 1'b0);
      sumIn = 1;
      for (int other = 0; other < 6; other++) begin
        if (other != sel) pulseSrc(other);
      end
      chk($sformatf("R7 sel %0d ignores other sources", sel), localOut, 1'b0);
      pulseSrc(sel);
      chk($sformatf("R7 sel %0d follows its source", sel), localOut, 1'b1);
    end
    doReset(2'd0, 3'd5, 0, 0, 0, 1'b0);
    sumIn = 1; ptClk = 1; @(negedge clk);
    sumIn = 0; ptClk = 0; @(negedge clk);
    chk("R7 sel 5 captures on rising ptClk", localOut, 1'b1);
    doReset(2'd0, 3'd6, 0, 0, 0, 1'b0);
    sumIn = 1; ptClk = 1; @(negedge clk);
    sumIn = 0; ptClk = 0; @(negedge clk);
    chk("R7 sel 6 captures on falling ptClk", localOut, 1'b0);
    sumIn = 1; ptClk = 1; @(negedge clk);
    ptClk = 0; @(negedge clk);
    chk("R7 sel 6 second falling edge", localOut, 1'b1);
    doReset(2'd0, 3'd7, 0, 0, 0, 1'b0);
    sumIn = 1;
    for (int s = 0; s < 6; s++) pulseSrc(s);
    chk("R7 sel 7 never updates", localOut, 1'b0);
  endtask

  task automatic testInit();
    doReset(2'd0, 3'd0, 0, 0, 0, 1'b1);
    sumIn = 0; pulseSrc(0);
    chk("R8 setup cleared", localOut, 1'b0);
    sharedInit = 1; #1;
    chk("R8 shared init immediate", localOut, 1'b1);
    chk("R11 outputs agree under init", globalOut, 1'b1);
    @(negedge clk); pulseSrc(0);
    chk("R8 init beats clock", localOut, 1'b1);
    sharedInit = 0; @(negedge clk);
    chk("R8 init value retained", localOut, 1'b1);
    doReset(2'd1, 3'd0, 0, 0, 0, 1'b0);
    sumIn = 1; pulseSrc(0);
    chk("R8 setup toggled to one", localOut, 1'b1);
    ptInit = 1; #1;
    chk("R8 per-cell init immediate", localOut, 1'b0);
    @(negedge clk); ptInit = 0; @(negedge clk);
    chk("R8 per-cell init retained", localOut, 1'b0);
  endtask

  task automatic testDirect();
    doReset(2'd0, 3'd0, 1, 1, 0, 1'b0);
    sumIn = 0; padIn = 1; pulseSrc(0);
    chk("R9 pad one captured", localOut, 1'b1);
    sumIn = 1; padIn = 0; pulseSrc(0);
    chk("R9 pad zero, logic and polarity ignored", localOut, 1'b0);
  endtask

  task automatic testDelay();
    doReset(2'd0, 3'd0, 0, 1, 1, 1'b0);
    padIn = 1; pulseSrc(0);
    chk("R10 delayed path still old value", localOut, 1'b0);
    repeat (2) @(negedge clk);
    pulseSrc(0);
    chk("R10 delayed path later new value", localOut, 1'b1);
    padIn = 0; @(negedge clk); pulseSrc(0);
    chk("R10 delayed path one edge is too soon", localOut, 1'b1);
    doReset(2'd0, 3'd0, 0, 1, 0, 1'b0);
    padIn = 1; pulseSrc(0);
    chk("R10 undelayed path immediate", localOut, 1'b1);
  endtask

  always @(negedge clk) begin
    if (rstN && (localOut !== globalOut)) begin
      errors++;
      $display("FAIL R11 globalOut %0b expected %0b", globalOut, localOut);
    end
  end

  initial begin
    testReset();
    testDMode();
    testXor();
    testToggle();
    testLatch();
    testEnable();
    testClkSel();
    testInit();
    testDirect();
    testDelay();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule